// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block sits on the link side of an 8-bit, single-data-rate ULPI bus. Every signal is sampled and driven on the rising clock edge. The PHY's direction line decides who owns the shared data bus. While the line is low, the controller may drive the bus. It sends a non-zero command byte and then the packet bytes, taking them from an upstream valid/ready byte stream. The PHY's NXT input paces every byte. After the final byte has been accepted, the controller closes the transfer with a one-cycle STP pulse. While the direction line is high, the PHY drives the bus. The controller forwards each received byte, marking it as packet data or as a status byte.

The data pins have a tri-state split: an output byte, an output enable and an input byte. Every change of the direction line costs one turnaround cycle. During that cycle the link drives nothing and no received byte counts as valid. The controller reports the turnaround to the receive side as a one-cycle flag. The PHY may take the bus in the middle of a link transmit. The controller then drops the transfer without issuing STP and signals an abort to the upstream source.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While reset is asserted, the output enable, STP, the output byte, tx_ready, tx_abort and all receive flags are low or zero.
- R2: The output enable is high exactly when the direction line is low in the current cycle and was also low in the previous cycle; it is low in every cycle with the direction line high.
- R3: A cycle in which the direction line differs from its previous value is a turnaround: the output enable and tx_ready are low in it, and in the following cycle rx_turn is high with rx_valid and rx_status low.
- R4: A first stream byte equal to 0x00 is consumed (tx_ready high) but starts no transfer; the bus keeps showing 0x00 and the controller stays idle.
- R5: A non-zero first byte accepted while idle appears on the output byte in the next cycle and starts a transmit.
- R6: While a transmitted byte waits with NXT low, it is held unchanged on the bus and tx_ready stays low.
- R7: When NXT is high during a transmit and the byte on the bus is not the last, tx_ready is high in that cycle, and the next stream byte is on the bus in the following cycle.
- R8: When NXT accepts the last byte (tx_last was set with it), STP is high for exactly the following cycle, with the output byte at 0x00 during it.
- R9: If the direction line rises during a transmit, tx_abort is high in that same cycle, the output enable drops, and no STP follows.
- R10: A byte seen with the direction line high in this and the previous cycle and NXT high appears on rx_data with rx_valid high one cycle later.
- R11: A byte seen with the direction line high in this and the previous cycle and NXT low appears on rx_data with rx_status high (rx_valid low) one cycle later.
- R12: If NXT accepts a non-last byte and the stream has no byte ready in that cycle, tx_abort is high in that cycle and the transfer ends with STP in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ulpi_dir | input | 1 | Bus direction from the PHY, high when the PHY owns the bus |
| ulpi_nxt | input | 1 | PHY pacing strobe |
| ulpi_stp | output | 1 | One-cycle stop pulse ending a link transmit |
| ulpi_data_in | input | 8 | Byte read from the data pins |
| ulpi_data_out | output | 8 | Byte driven onto the data pins |
| ulpi_data_oe | output | 1 | Output enable for the data pins |
| tx_valid | input | 1 | Upstream byte available |
| tx_data | input | 8 | Upstream byte; the first of a packet is the command |
| tx_last | input | 1 | Marks the final byte of a packet |
| tx_ready | output | 1 | Upstream byte is taken at this edge |
| tx_abort | output | 1 | Current transmit was cut short |
| rx_valid | output | 1 | rx_data holds a received packet byte |
| rx_status | output | 1 | rx_data holds a status byte |
| rx_data | output | 8 | Received byte |
| rx_turn | output | 1 | A bus turnaround occurred in the previous cycle |

## Verification
The assertions assume that the upstream stream keeps tx_data and tx_last stable only within the cycle in which tx_ready is sampled. They also assume that the PHY asserts NXT only for bytes it means to take. The hold and single-cycle STP properties rely on the direction line staying low while a byte waits. The bench drives every input at the falling edge, offers a new upstream byte only after a handshake it has seen, and toggles the direction line at random. Those random toggles exercise aborts, turnarounds and status bytes inside these assumptions.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;

  localparam int unsigned BUS_W = 8;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_XMIT = 2'd1,
    TX_STOP = 2'd2
  } tx_state_t;

  // A zero byte on the link side means "no command".
  function automatic logic is_idle_byte(input logic [BUS_W-1:0] b);
    return (b == '0);
  endfunction

endpackage

// File: rtl/ulpi_dir_track.sv
module ulpi_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  output logic link_own,
  output logic phy_own,
  output logic turn_evt
);

  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir;
  end

  assign turn_evt = rst_n && (dir != dir_q);
  assign link_own = rst_n && !dir && !dir_q;
  assign phy_own  = rst_n && dir && dir_q;

  a_r3_turn_blocks_link: assert property (@(posedge clk) disable iff (!rst_n)
    turn_evt |-> !link_own);

  a_r3_owner_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_own && phy_own));

endmodule

// File: rtl/ulpi_tx_engine.sv
module ulpi_tx_engine
  import ulpi_link_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_own,
  input  logic              dir,
  input  logic              nxt,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic              tx_abort,
  output logic [DATA_W-1:0] data_out,
  output logic              stp
);

  tx_state_t         state, state_d;
  logic [DATA_W-1:0] hold_byte;
  logic              hold_last;

  logic idle_take, first_load, zero_drop;
  logic byte_taken, more_load, underrun, dir_abort, last_done;

  assign idle_take  = (state == TX_IDLE) && link_own && tx_valid;
  assign first_load = idle_take && !is_idle_byte(tx_data);
  assign zero_drop  = idle_take && is_idle_byte(tx_data);
  assign dir_abort  = (state == TX_XMIT) && dir;
  assign byte_taken = (state == TX_XMIT) && !dir && nxt;
  assign more_load  = byte_taken && !hold_last && tx_valid;
  assign underrun   = byte_taken && !hold_last && !tx_valid;
  assign last_done  = byte_taken && hold_last;

  assign tx_ready = ((state == TX_IDLE) && link_own) || (byte_taken && !hold_last);
  assign tx_abort = dir_abort || underrun;
  assign data_out = (state == TX_XMIT) ? hold_byte : '0;
  assign stp      = (state == TX_STOP);

  always_comb begin
    state_d = state;
    unique case (state)
      TX_IDLE: if (first_load) state_d = TX_XMIT;
      TX_XMIT: begin
        if (dir_abort)                   state_d = TX_IDLE;
        else if (last_done || underrun)  state_d = TX_STOP;
      end
      TX_STOP: state_d = TX_IDLE;
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      hold_byte <= '0;
      hold_last <= 1'b0;
    end else begin
      state <= state_d;
      if (first_load || more_load) begin
        hold_byte <= tx_data;
        hold_last <= tx_last;
      end
    end
  end

  a_r4_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    zero_drop |=> (state == TX_IDLE));

  a_r5_cmd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    first_load |=> (data_out != '0));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TX_XMIT) && !nxt && !dir) |=> $stable(data_out));

  a_r6_no_ready_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TX_XMIT) && !nxt) |-> !tx_ready);

  a_r8_stp_single: assert property (@(posedge clk) disable iff (!rst_n)
    stp |=> !stp);

  a_r8_stp_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> stp);

  a_r9_no_stp_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    dir_abort |=> !stp);

endmodule

// File: rtl/ulpi_rx_path.sv
module ulpi_rx_path
  import ulpi_link_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_own,
  input  logic              turn_evt,
  input  logic              nxt,
  input  logic [DATA_W-1:0] data_in,
  output logic              rx_valid,
  output logic              rx_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_turn
);

  logic pkt_evt, sts_evt;

  assign pkt_evt = phy_own && nxt;
  assign sts_evt = phy_own && !nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_status <= 1'b0;
      rx_data   <= '0;
      rx_turn   <= 1'b0;
    end else begin
      rx_valid  <= pkt_evt;
      rx_status <= sts_evt;
      rx_turn   <= turn_evt;
      if (phy_own) rx_data <= data_in;
    end
  end

  a_r3_turn_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_turn |-> (!rx_valid && !rx_status));

  a_r10_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_status);

  a_r11_status_data: assert property (@(posedge clk) disable iff (!rst_n)
    sts_evt |=> (rx_status && rx_data == $past(data_in)));

endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl
  import ulpi_link_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  output logic              ulpi_stp,
  input  logic [DATA_W-1:0] ulpi_data_in,
  output logic [DATA_W-1:0] ulpi_data_out,
  output logic              ulpi_data_oe,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic              tx_abort,
  output logic              rx_valid,
  output logic              rx_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_turn
);

  logic link_own, phy_own, turn_evt;

  ulpi_dir_track u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir      (ulpi_dir),
    .link_own (link_own),
    .phy_own  (phy_own),
    .turn_evt (turn_evt)
  );

  ulpi_tx_engine #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_own (link_own),
    .dir      (ulpi_dir),
    .nxt      (ulpi_nxt),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .tx_abort (tx_abort),
    .data_out (ulpi_data_out),
    .stp      (ulpi_stp)
  );

  ulpi_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .phy_own   (phy_own),
    .turn_evt  (turn_evt),
    .nxt       (ulpi_nxt),
    .data_in   (ulpi_data_in),
    .rx_valid  (rx_valid),
    .rx_status (rx_status),
    .rx_data   (rx_data),
    .rx_turn   (rx_turn)
  );

  assign ulpi_data_oe = link_own;

  a_r2_release_on_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_dir |-> !ulpi_data_oe);

  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort && ulpi_dir) |-> (!ulpi_data_oe && !ulpi_stp));

endmodule

// File: tb/ulpi_link_ctrl_test.sv
module ulpi_link_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir, nxt, stp, oe;
  logic [7:0] din, dout;
  logic       tx_valid, tx_last, tx_ready, tx_abort;
  logic [7:0] tx_data;
  logic       rx_valid, rx_status, rx_turn;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  ulpi_link_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_stp(stp),
    .ulpi_data_in(din), .ulpi_data_out(dout), .ulpi_data_oe(oe),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_abort(tx_abort),
    .rx_valid(rx_valid), .rx_status(rx_status), .rx_data(rx_data), .rx_turn(rx_turn)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] pkt [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {valid, status, turn} one cycle after the inputs
  function automatic logic [2:0] exp_rx(input logic d, input logic pd, input logic n);
    return {d && pd && n, d && pd && !n, d != pd};
  endfunction

  function automatic logic exp_oe(input logic d, input logic pd);
    return !d && !pd;
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic pd;
    logic [2:0] e;
    void'($urandom(32'h5eed_0421));
    rst_n = 0; dir = 0; nxt = 0; din = 0;
    tx_valid = 0; tx_data = 0; tx_last = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!stp && dout == 0 && !oe && !tx_ready && !tx_abort, "R1 tx side", {stp, oe, tx_ready, tx_abort}, 0);
    chk(!rx_valid && !rx_status && !rx_turn, "R1 rx side", {rx_valid, rx_status, rx_turn}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(oe == 1, "R2 oe when link owns", oe, 1);
    chk(tx_ready == 1, "R4 idle ready", tx_ready, 1);

    // R4 zero command dropped
    tx_valid = 1; tx_data = 8'h00; tx_last = 0; #1;
    chk(tx_ready == 1, "R4 zero consumed", tx_ready, 1);
    @(negedge clk);
    chk(dout == 8'h00, "R4 bus idle", dout, 0);
    chk(tx_ready == 1 && !stp, "R4 still idle", tx_ready, 1);

    // R5 command byte
    tx_data = 8'h41;
    @(negedge clk);
    chk(dout == 8'h41, "R5 command on bus", dout, 8'h41);
    tx_data = 8'h11; #1;
    chk(!tx_ready, "R6 no ready while waiting", tx_ready, 0);
    @(negedge clk);
    chk(dout == 8'h41, "R6 byte held", dout, 8'h41);
    nxt = 1; #1;
    chk(tx_ready == 1, "R7 ready with nxt", tx_ready, 1);
    @(negedge clk);
    chk(dout == 8'h11, "R7 next byte", dout, 8'h11);
    tx_data = 8'h22; tx_last = 1; #1;
    chk(tx_ready == 1, "R7 ready second", tx_ready, 1);
    @(negedge clk);
    chk(dout == 8'h22, "R7 last byte on bus", dout, 8'h22);
    tx_valid = 0; tx_last = 0; nxt = 0;
    @(negedge clk);
    chk(dout == 8'h22 && !stp, "R6 last held", dout, 8'h22);
    nxt = 1; #1;
    chk(!tx_ready, "R8 no ready on last", tx_ready, 0);
    @(negedge clk);
    chk(stp == 1 && dout == 0, "R8 stp pulse", {stp, dout}, 9'h100);
    nxt = 0;
    @(negedge clk);
    chk(stp == 0, "R8 stp one cycle", stp, 0);

    // R9 abort by direction change
    tx_valid = 1; tx_data = 8'h43; tx_last = 0;
    @(negedge clk);
    chk(dout == 8'h43, "R5 second command", dout, 8'h43);
    tx_valid = 0; dir = 1; #1;
    chk(tx_abort == 1, "R9 abort flagged", tx_abort, 1);
    chk(oe == 0, "R9 oe released", oe, 0);
    @(negedge clk);
    chk(!tx_abort && !stp, "R9 no stp", {tx_abort, stp}, 0);
    chk(rx_turn && !rx_valid && !rx_status, "R3 turn flag", {rx_turn, rx_valid, rx_status}, 3'b100);

    // R10 / R11 directed receive
    din = 8'hA5; nxt = 1;
    @(negedge clk);
    chk(rx_valid && !rx_status && rx_data == 8'hA5, "R10 rx data", rx_data, 8'hA5);
    din = 8'h3C; nxt = 0;
    @(negedge clk);
    chk(rx_status && !rx_valid && rx_data == 8'h3C, "R11 status byte", rx_data, 8'h3C);

    // R3 falling direction turnaround
    dir = 0; #1;
    chk(!oe && !tx_ready, "R3 turnaround blocks link", {oe, tx_ready}, 0);
    @(negedge clk);
    chk(rx_turn && !rx_valid && !rx_status, "R3 turn after fall", {rx_turn, rx_valid, rx_status}, 3'b100);
    #1;
    chk(oe == 1, "R2 oe back", oe, 1);

    // R12 underrun
    tx_valid = 1; tx_data = 8'h44; tx_last = 0;
    @(negedge clk);
    tx_valid = 0; nxt = 1; #1;
    chk(tx_ready && tx_abort, "R12 underrun abort", {tx_ready, tx_abort}, 2'b11);
    @(negedge clk);
    chk(stp == 1, "R12 stp after underrun", stp, 1);
    nxt = 0;
    @(negedge clk);
    chk(stp == 0, "R12 stp ends", stp, 0);

    // random receive and ownership phase
    pd = 0;
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 6) == 0) dir = ~dir;
      nxt = $urandom % 2;
      din = $urandom;
      #1;
      chk(oe == exp_oe(dir, pd), "R2 random oe", oe, exp_oe(dir, pd));
      chk(tx_ready == exp_oe(dir, pd), "R3 random ready", tx_ready, exp_oe(dir, pd));
      e = exp_rx(dir, pd, nxt);
      @(negedge clk);
      chk({rx_valid, rx_status, rx_turn} == e, "R10 R11 random flags", {rx_valid, rx_status, rx_turn}, e);
      if (e[2:1] != 0) chk(rx_data == din, "R10 random data", rx_data, din);
      pd = dir;
    end
    dir = 0; nxt = 0;
    repeat (2) @(negedge clk);

    // random transmit packets with random pacing
    for (int p = 0; p < 25; p++) begin
      int len, sent, cur, guard;
      bit stp_exp, done, hs, acc;
      len = 1 + ($urandom % 6);
      for (int j = 0; j < 8; j++) pkt[j] = $urandom;
      if (pkt[0] == 0) pkt[0] = 8'h5A;
      sent = 0; cur = -1; stp_exp = 0; done = 0; guard = 0;
      while (!done && guard < 200) begin
        guard++;
        chk(stp == stp_exp, "R8 random stp", stp, stp_exp);
        if (cur >= 0) chk(dout == pkt[cur], "R7 random bus byte", dout, pkt[cur]);
        if (stp_exp) begin
          done = 1;
          tx_valid = 0;
          nxt = 0;
        end else begin
          tx_valid = (sent < len);
          tx_data  = pkt[sent];
          tx_last  = (sent == len - 1);
          nxt      = $urandom % 2;
          #1;
          if (cur >= 0)
            chk(tx_ready == (nxt && cur != len - 1), "R6 random ready", tx_ready, nxt && cur != len - 1);
          hs  = tx_ready && tx_valid;
          acc = (cur >= 0) && nxt;
          stp_exp = acc && (cur == len - 1);
          if (hs) begin
            cur = sent;
            sent++;
          end else if (acc) begin
            cur = -1;
          end
        end
        @(negedge clk);
      end
      chk(done, "R8 packet completed", done, 1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule